// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the bus-facing controller of a byte-wide serial EEPROM with a 17-bit address space. It watches oversampled two-wire clock and data inputs and detects start and stop conditions. It accepts a device address byte that carries two chip-select bits and the top address bit. It acknowledges by pulling the data line low through an open-drain enable. It drives a memory array that lives outside the block, through a synchronous port: the address and write-enable are presented in one cycle, and the read data comes back registered on the next.

Writes are gathered in a page buffer and reach the array only after a stop condition. That stop starts a timed busy window. During the window the controller stays off the bus, so a host can poll with a start and an address byte until it receives an acknowledge. Reads return bytes from an internal pointer and keep going while the host acknowledges. A write-protect input blocks every array update.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the data-line enable `sda_oe_o` is low and `mem_we_o` is low.
- R2: An address byte is accepted only when bits 7:4 are 1010 and bits 3:2 equal `strap_i[1:0]`. Bit 1 is the page bit and bit 0 selects read (1) or write (0). When the byte is accepted, the target pulls SDA low during the ninth clock. Any other byte gets no acknowledge and the target drives nothing until the next start.
- R3: In write mode the next two bytes, high byte first, are acknowledged. The page bit from the address byte, then the high byte, then the low byte form the 17-bit pointer.
- R4: Data bytes reach the array only when a stop follows them. A repeated start discards the buffered bytes without writing any of them.
- R5: Each data byte is acknowledged. After each byte the low 8 address bits step by one and wrap from 0xFF to 0x00 inside the same page; the upper 9 bits never change. A later byte for the same location replaces the earlier one.
- R6: With `wp_i` high at the stop, data bytes are still acknowledged, but no array write happens and no busy window starts, so an immediate poll is acknowledged.
- R7: After a committing stop, for `TWR_CYCLES` clocks no address byte is acknowledged and SDA is never driven. After the window, a poll is acknowledged.
- R8: A read-mode address byte with no preceding address phase returns the byte at the pointer. After a write the pointer holds the last written location plus one, with the page wrap of R5.
- R9: A write-mode address byte and two address bytes, then a repeated start with a read-mode address byte, returns the byte at the loaded 17-bit address.
- R10: While the host acknowledges each byte, the target sends the following locations in turn, with the pointer wrapping from 0x1FFFF to 0x00000. A non-acknowledge ends the read.
- R11: Bytes go MSB first. The target changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock, asynchronous |
| sda_i | input | 1 | Resolved bus data line, asynchronous |
| strap_i | input | 2 | Chip-select straps matched against address bits 3:2 |
| wp_i | input | 1 | Write protect, high blocks array writes |
| sda_oe_o | output | 1 | High pulls the data line low |
| mem_addr_o | output | 17 | Array address |
| mem_we_o | output | 1 | Array write enable |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one cycle after the address |

## Verification
The bench builds the block with `PAGE_BITS` = 8 and `TWR_CYCLES` = 600. With that window, both sides of the busy window can be reached in a few hundred cycles: the NACKed poll inside it and the acknowledged poll after it. The full 256-byte page keeps the 0xFF-to-0x00 wrap of page writes in reach. The 17-bit pointer lets sequential reads cross from 0x1FFFF to zero.

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int PAGE_BITS  = 8,
  parameter int TWR_CYCLES = 625000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  strap_i,
  input  logic        wp_i,
  output logic        sda_oe_o,
  output logic [16:0] mem_addr_o,
  output logic        mem_we_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i
);
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int TW   = $clog2(TWR_CYCLES + 1);
  localparam logic [TW-1:0]        TLAST  = TW'(TWR_CYCLES - 1);
  localparam logic [TW-1:0]        TPAGE  = TW'(PAGE);
  localparam logic [TW-1:0]        TONE   = TW'(1);
  localparam logic [PAGE_BITS-1:0] PONE   = PAGE_BITS'(1);
  localparam logic [16:0]          AONE   = 17'd1;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_ACKW, S_TX, S_RACK} st_t;

  st_t            st, nxt;
  logic [2:0]     scl_r, sda_r;
  logic [3:0]     cnt;
  logic [7:0]     sh, tx;
  logic [16:0]    ptr;
  logic           p0, mack, busy;
  logic [TW-1:0]  tmr;
  logic [PAGE-1:0] mask;
  logic [7:0]     pbuf [PAGE];

  wire scl_s   = scl_r[1];
  wire scl_p   = scl_r[2];
  wire sda_s   = sda_r[1];
  wire sda_p   = sda_r[2];
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire byte_done = fall && cnt == 4'd8;
  wire active  = !busy && !start_c && !stop_c;
  wire wr_byte = active && st == S_WDAT && byte_done;
  wire commit  = busy && tmr < TPAGE;
  wire [PAGE_BITS-1:0] cidx = tmr[PAGE_BITS-1:0];

  assign sda_oe_o    = (st == S_ACKW) || (st == S_TX && !tx[7]);
  assign mem_addr_o  = commit ? {ptr[16:PAGE_BITS], cidx} : ptr;
  assign mem_we_o    = commit && mask[cidx];
  assign mem_wdata_o = pbuf[cidx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  always_ff @(posedge clk)
    if (wr_byte) pbuf[ptr[PAGE_BITS-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; p0 <= 1'b0; mack <= 1'b0; busy <= 1'b0; tmr <= '0; mask <= '0;
    end else if (busy) begin
      st  <= S_IDLE;
      tmr <= tmr + TONE;
      if (tmr == TLAST) begin
        busy <= 1'b0;
        mask <= '0;
      end
    end else if (start_c) begin
      st <= S_DEV; cnt <= '0; mask <= '0;
    end else if (stop_c) begin
      st <= S_IDLE;
      if (|mask && !wp_i) begin
        busy <= 1'b1;
        tmr  <= '0;
      end else mask <= '0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO, S_WDAT:
          if (rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            st  <= S_ACKW;
            case (st)
              S_DEV:
                if (sh[7:4] == 4'b1010 && sh[3:2] == strap_i) begin
                  p0  <= sh[1];
                  nxt <= sh[0] ? S_TX : S_AHI;
                end else st <= S_IDLE;
              S_AHI: begin
                ptr[16:8] <= {p0, sh};
                nxt <= S_ALO;
              end
              S_ALO: begin
                ptr[7:0] <= sh;
                mask <= '0;
                nxt <= S_WDAT;
              end
              default: begin
                mask[ptr[PAGE_BITS-1:0]] <= 1'b1;
                ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + PONE;
                nxt <= S_WDAT;
              end
            endcase
          end
        S_ACKW:
          if (fall) begin
            cnt <= '0;
            st  <= nxt;
            if (nxt == S_TX) begin
              tx  <= mem_rdata_i;
              ptr <= ptr + AONE;
            end
          end
        S_TX:
          if (fall) begin
            if (cnt == 4'd7) begin
              st  <= S_RACK;
              cnt <= '0;
            end else begin
              tx  <= {tx[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
        S_RACK:
          if (rise) mack <= ~sda_s;
          else if (fall) begin
            if (mack) begin
              tx  <= mem_rdata_i;
              ptr <= ptr + AONE;
              st  <= S_TX;
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end

  a_r11_sda_moves_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  a_r7_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_o);

  a_r6_protect_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && wp_i && !busy) |=> !busy);

  a_r4_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_c));

  a_r2_reject_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == S_DEV && byte_done && sh[7:4] != 4'b1010) |=> !sda_oe_o);

  a_r5_page_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> $stable(ptr[16:PAGE_BITS]));
endmodule

// File: tb/sim_eeprom_i2c_target.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_target;
  localparam int TWR = 600;
  localparam int Q   = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe, mem_we;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  wire sda_line = sda_m & ~sda_oe;

  eeprom_i2c_target #(.PAGE_BITS(8), .TWR_CYCLES(TWR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .wp_i(wp), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  int checks = 0, errors = 0;
  logic [7:0] arr [int];
  logic [7:0] model [int];
  int wq_exp [$];
  logic [7:0] dq [$];
  int exp_ptr = 0;
  logic prev_oe = 1'b0;

  function automatic logic [7:0] seed(int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] mval(int a);
    return model.exists(a) ? model[a] : seed(a);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    mem_rdata <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : seed(int'(mem_addr));
    if (mem_we) arr[int'(mem_addr)] = mem_wdata;
  end

  always @(posedge clk) if (rst_n) begin
    #1;
    if (mem_we) begin
      if (wq_exp.size() == 0) chk(0, "R4 unexpected array write", {mem_addr, mem_wdata}, 0);
      else begin
        chk({mem_addr, mem_wdata} == 25'(wq_exp[0]), "R5 array write order/value",
            {mem_addr, mem_wdata}, wq_exp[0]);
        void'(wq_exp.pop_front());
      end
    end
    if (sda_oe !== prev_oe && scl_m) chk(0, "R11 sda_oe moved with SCL high", sda_oe, prev_oe);
    prev_oe = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] devb(bit p, bit rd);
    return {4'b1010, strap, p, rd};
  endfunction

  task automatic poll(bit exp_ack, string req);
    bit a;
    bstart(); send(devb(1'b0, 1'b0), a); chk(a == exp_ack, req, a, exp_ack); bstop();
  endtask

  task automatic wr(int addr, bit do_stop);
    bit a;
    logic [7:0] pg [int];
    int page, lo;
    page = addr >> 8; lo = addr & 255;
    bstart();
    send(devb(addr[16], 1'b0), a); chk(a, "R2 address byte ack", a, 1);
    send(8'(addr >> 8), a);        chk(a, "R3 high address ack", a, 1);
    send(8'(addr), a);             chk(a, "R3 low address ack", a, 1);
    for (int k = 0; k < dq.size(); k++) begin
      send(dq[k], a); chk(a, "R5 data byte ack", a, 1);
      pg[(lo + k) % 256] = dq[k];
    end
    exp_ptr = page * 256 + (lo + dq.size()) % 256;
    if (do_stop) begin
      if (!wp && dq.size() > 0)
        for (int i = 0; i < 256; i++) if (pg.exists(i)) begin
          wq_exp.push_back((page * 256 + i) * 256 + int'(pg[i]));
          model[page * 256 + i] = pg[i];
        end
      bstop();
    end
  endtask

  task automatic rd(int n, string req);
    bit a;
    logic [7:0] b;
    bstart();
    send(devb(1'b0, 1'b1), a); chk(a, "R8 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv(k < n - 1, b);
      chk(b == mval(exp_ptr), req, b, mval(exp_ptr));
      exp_ptr = (exp_ptr + 1) & 32'h1FFFF;
    end
    bstop();
  endtask

  task automatic rand_rd(int addr, int n, string req);
    dq.delete(); wr(addr, 1'b0); rd(n, req);
  endtask

  task automatic after_commit();
    poll(1'b0, "R7 poll during busy window");
    repeat (TWR) @(negedge clk);
    poll(1'b1, "R7 poll after busy window");
  endtask

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(mem_we == 1'b0, "R1 reset mem_we", mem_we, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    bstart(); send({4'b1010, ~strap, 2'b00}, a); chk(!a, "R2 strap mismatch no ack", a, 0); bstop();
    bstart(); send({4'b1011, strap, 2'b00}, a); chk(!a, "R2 prefix mismatch no ack", a, 0); bstop();

    dq = '{8'hA5}; wr(32'h12345, 1'b1);
    after_commit();
    chk(wq_exp.size() == 0, "R4 byte write committed", wq_exp.size(), 0);
    rand_rd(32'h12345, 3, "R9 R10 random then sequential read");

    dq = '{8'h11, 8'h22, 8'h33, 8'h44}; wr(32'h007FE, 1'b1);
    after_commit();
    exp_ptr = 32'h00702;
    rd(2, "R8 current address after page wrap");
    rand_rd(32'h007FE, 2, "R5 page tail bytes");
    rand_rd(32'h00700, 2, "R5 page head bytes wrapped");

    wp = 1'b1;
    dq = '{8'hDE, 8'hAD}; wr(32'h00010, 1'b1);
    poll(1'b1, "R6 no busy window under protect");
    wp = 1'b0;
    rand_rd(32'h00010, 2, "R6 protected bytes unchanged");

    dq = '{8'h77, 8'h88}; wr(32'h00020, 1'b0);
    rand_rd(32'h00020, 2, "R4 repeated start discards data");
    poll(1'b1, "R4 no busy after discarded write");

    dq = '{8'h5A, 8'h6B}; wr(32'h1FFFF, 1'b1);
    after_commit();
    rand_rd(32'h1FFFF, 2, "R10 pointer wraps to zero");

    dq = '{8'hC3}; wr(32'h0ABCD, 1'b1);
    after_commit();
    rand_rd(32'h0ABCD, 1, "R11 MSB first byte C3");

    chk(wq_exp.size() == 0, "R4 all expected writes seen", wq_exp.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule